// File: doc/BRIEF.md
# Lock Elision Region Controller

This controller lets a single thread run a lock-protected region speculatively instead of actually taking the lock. A store carrying an acquire hint normally writes the lock. Here that store is absorbed: the lock address goes into a small tracking table and the new lock value is held locally. Memory never sees the write, so every other agent still observes the lock as free. While the region is open, a load from a tracked lock address is answered from the local copy.

A store carrying a release hint that matches a tracked lock retires that entry. The release that empties the table closes the region and raises a commit request. Nothing needs to be restored in memory, because the lock was never written. Several events force a re-execute request and drop every buffered lock value:

- an external abort (conflict) signal;
- a plain store to a tracked lock;
- a second acquire of a lock that is already tracked;
- an acquire that crosses a cache line while the region is open.

After an abort, the thread replays the region with ordinary locking. Acquires and releases are passed on to memory until the replayed outermost lock is released.

Requests arrive on a valid/ready channel. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` drops for exactly the one cycle in which `reexec_req` is high, so no request can be accepted while the region is being torn down. Every accepted request yields, one cycle later, exactly one of the following:
- a `fwd_valid` pulse, meaning the request must be issued to memory unchanged;
- an `rd_valid` pulse carrying `rd_data`;
- silent absorption;
- an abort.

`rd_valid` is a single-cycle pulse and takes no back-pressure.

Top module: `lock_elide_ctrl`

## Requirements
- R1: After reset `region_active`, `commit_req`, `reexec_req`, `fwd_valid` and `rd_valid` are 0, and `req_ready` is 1.
- R2: An accepted store with `req_hint`=1 (acquire) that fits in one 64-byte line, targets an untracked address, and finds a free slot outside replay is absorbed. In the next cycle `fwd_valid` is 0 and `region_active` is 1. An access whose last byte is the final byte of a line counts as fitting.
- R3: An accepted load (`req_write`=0) from a tracked lock address gives `rd_valid`=1 and `rd_data` equal to the buffered acquire value in the next cycle, with `fwd_valid`=0.
- R4: Loads and plain stores (`req_hint`=0) to untracked addresses are forwarded: `fwd_valid`=1 in the next cycle, and no abort occurs.
- R5: An acquire whose bytes cross a 64-byte boundary, where the byte count is 2^`req_size`, is forwarded when no region is open. While a region is open, the same acquire raises `reexec_req`.
- R6: At most 2 locks are tracked at once. A further acquire is forwarded without abort and leaves the region open.
- R7: A plain store to a tracked lock address raises `reexec_req` and clears `region_active`.
- R8: An acquire to an address that is already tracked raises `reexec_req`.
- R9: A store with `req_hint`=2 (release) to a tracked address frees that entry. If other entries remain, no commit occurs. If it was the last entry, `commit_req` pulses and `region_active` falls.
- R10: A release to an untracked address is forwarded as a normal store.
- R11: `abort_in` while a region is open gives `reexec_req`=1 and `req_ready`=0 in the next cycle, and drops all buffered locks. `abort_in` with no region open has no effect.
- R12: After any abort, acquires and releases are forwarded and not elided. This lasts until the release that balances the first replayed acquire, after which elision resumes.
- R13: When `abort_in` coincides with the outermost release, the abort wins: `reexec_req`=1 and `commit_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 store, 0 load |
| req_hint | input | 2 | Store hint: 0 none, 1 acquire, 2 release (ignored on loads) |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | log2 of access byte count |
| req_wdata | input | 32 | Store data |
| abort_in | input | 1 | Conflict / external abort |
| region_active | output | 1 | Speculative region open |
| commit_req | output | 1 | Pulse: outermost release, commit |
| reexec_req | output | 1 | Pulse: region aborted, replay with locking |
| fwd_valid | output | 1 | Pulse: accepted request goes to memory unchanged |
| rd_valid | output | 1 | Pulse: lock read served locally |
| rd_data | output | 32 | Buffered lock value |

## Verification
Two outcomes can fall in the same cycle: the commit raised by the outermost release and an abort from the conflict input. The bench opens a region with one acquire. It then drives the matching release with `abort_in` high on the same edge. It expects a re-execute pulse with no commit pulse. A follow-up load of the lock must then be forwarded, which shows the entry was discarded rather than committed.

// File: rtl/le_pkg.sv
package le_pkg;
  typedef enum logic [1:0] {
    HINT_NONE = 2'd0,
    HINT_ACQ  = 2'd1,
    HINT_REL  = 2'd2
  } hint_e;
endpackage

// File: rtl/le_line_check.sv
module le_line_check #(
  parameter int LINE_BYTES = 64,
  localparam int LOFF = $clog2(LINE_BYTES)
) (
  input  logic [LOFF-1:0] addr_off,
  input  logic [1:0]      size_log2,
  output logic            crosses
);
  localparam int EW = LOFF + 4;
  logic [EW-1:0] end_byte;
  always_comb begin
    end_byte = EW'(addr_off) + (EW'(1) << size_log2);
    crosses  = end_byte > EW'(LINE_BYTES);
  end
endmodule

// File: rtl/le_lock_table.sv
module le_lock_table #(
  parameter int N  = 2,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [DW-1:0] hit_data,
  output logic          full,
  output logic [CW-1:0] count,
  input  logic          alloc,
  input  logic [DW-1:0] alloc_data,
  input  logic          free_en
);
  logic [N-1:0]  vld;
  logic [AW-1:0] tag [N];
  logic [DW-1:0] val [N];
  logic [IW-1:0] free_slot;

  always_comb begin
    hit = 1'b0; hit_idx = '0; hit_data = '0; free_slot = '0; count = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_slot = IW'(i);
    end
    for (int i = 0; i < N; i++) begin
      count = count + CW'(vld[i]);
      if (vld[i] && tag[i] == look_addr) begin
        hit = 1'b1; hit_idx = IW'(i); hit_data = val[i];
      end
    end
    full = &vld;
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        vld[g] <= 1'b0;
      end else if (alloc && free_slot == IW'(g)) begin
        vld[g] <= 1'b1;
        tag[g] <= look_addr;
        val[g] <= alloc_data;
      end else if (free_en && hit_idx == IW'(g)) begin
        vld[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lock_elide_ctrl.sv
module lock_elide_ctrl #(
  parameter int LOCKS      = 2,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int RPL_W      = 4,
  localparam int IW   = (LOCKS > 1) ? $clog2(LOCKS) : 1,
  localparam int CW   = $clog2(LOCKS + 1),
  localparam int LOFF = $clog2(LINE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_hint,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  input  logic          abort_in,
  output logic          region_active,
  output logic          commit_req,
  output logic          reexec_req,
  output logic          fwd_valid,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  import le_pkg::*;

  logic          acc, is_acq, is_rel, is_st, is_ld;
  logic          hit, full, crosses;
  logic [IW-1:0] hit_idx;
  logic [DW-1:0] hit_data;
  logic [CW-1:0] count;
  logic          replay;
  logic [RPL_W-1:0] rpl_cnt;
  logic          abort_now, alloc, free_en, commit_now, fwd_now, rd_now;

  le_lock_table #(.N(LOCKS), .AW(AW), .DW(DW)) u_table (
    .clk(clk), .rst_n(rst_n), .clear(abort_now),
    .look_addr(req_addr), .hit(hit), .hit_idx(hit_idx), .hit_data(hit_data),
    .full(full), .count(count),
    .alloc(alloc), .alloc_data(req_wdata), .free_en(free_en)
  );

  le_line_check #(.LINE_BYTES(LINE_BYTES)) u_line (
    .addr_off(req_addr[LOFF-1:0]), .size_log2(req_size), .crosses(crosses)
  );

  assign region_active = (count != '0);
  assign req_ready     = !reexec_req;

  always_comb begin
    acc    = req_valid && req_ready;
    is_acq = acc && req_write && req_hint == HINT_ACQ;
    is_rel = acc && req_write && req_hint == HINT_REL;
    is_st  = acc && req_write && !(req_hint == HINT_ACQ || req_hint == HINT_REL);
    is_ld  = acc && !req_write;

    abort_now = (abort_in && region_active)
             || (is_acq && !replay && crosses && region_active)
             || (is_acq && !replay && hit)
             || (is_st && hit);
    alloc      = is_acq && !replay && !crosses && !hit && !full && !abort_now;
    free_en    = is_rel && hit && !abort_now;
    commit_now = free_en && count == CW'(1);
    rd_now     = is_ld && hit && !abort_now;
    fwd_now    = !abort_now && ((is_ld && !hit) || (is_st && !hit)
                 || (is_acq && !alloc) || (is_rel && !hit));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_req <= 1'b0;
      reexec_req <= 1'b0;
      fwd_valid  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      replay     <= 1'b0;
      rpl_cnt    <= '0;
    end else begin
      commit_req <= commit_now;
      reexec_req <= abort_now;
      fwd_valid  <= fwd_now;
      rd_valid   <= rd_now;
      if (rd_now) rd_data <= hit_data;
      if (abort_now) begin
        replay  <= 1'b1;
        rpl_cnt <= '0;
      end else if (replay) begin
        if (is_acq && rpl_cnt != '1) begin
          rpl_cnt <= rpl_cnt + 1'b1;
        end else if (is_rel && rpl_cnt == RPL_W'(1)) begin
          replay  <= 1'b0;
          rpl_cnt <= '0;
        end else if (is_rel && rpl_cnt != '0) begin
          rpl_cnt <= rpl_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lock_elide_ctrl_chk.sv
module lock_elide_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [1:0] req_hint,
  input logic       region_active,
  input logic       commit_req,
  input logic       reexec_req,
  input logic       fwd_valid,
  input logic       rd_valid
);
  p_commit_vs_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_req && reexec_req));
  p_stall_on_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reexec_req |-> !req_ready);
  p_abort_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reexec_req |-> !region_active);
  p_commit_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> !region_active);
  p_local_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !fwd_valid);
  p_open_by_acquire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(region_active) |-> $past(req_valid && req_ready && req_write && req_hint == 2'd1));
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, rd_valid, reexec_req}));
endmodule

bind lock_elide_ctrl lock_elide_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_hint(req_hint), .region_active(region_active),
  .commit_req(commit_req), .reexec_req(reexec_req), .fwd_valid(fwd_valid),
  .rd_valid(rd_valid)
);

// File: tb/lock_elide_ctrl_tb.sv
module lock_elide_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, abort_in = 1'b0;
  logic [1:0]  req_hint = 2'd0, req_size = 2'd2;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, region_active, commit_req, reexec_req, fwd_valid, rd_valid;
  logic [31:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_elide_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_hint(req_hint), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .abort_in(abort_in),
    .region_active(region_active), .commit_req(commit_req), .reexec_req(reexec_req),
    .fwd_valid(fwd_valid), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  localparam logic [31:0] LA = 32'h100, LC = 32'h140, LD = 32'h180, LB = 32'h200;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic req(logic w, logic [1:0] h, logic [31:0] a, logic [1:0] sz,
                     logic [31:0] d, logic ab);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_hint = h; req_addr = a;
    req_size = sz; req_wdata = d; abort_in = ab;
    @(posedge clk); #1;
    req_valid = 1'b0; abort_in = 1'b0;
  endtask

  task automatic acq(logic [31:0] a, logic [31:0] d); req(1, 2'd1, a, 2'd2, d, 0); endtask
  task automatic rel(logic [31:0] a);                  req(1, 2'd2, a, 2'd2, 0, 0); endtask
  task automatic ld(logic [31:0] a);                   req(0, 2'd0, a, 2'd2, 0, 0); endtask
  task automatic st(logic [31:0] a);                   req(1, 2'd0, a, 2'd2, 32'h5, 0); endtask

  task automatic leave_replay();
    acq(LA, 1); chk("R12 replay acq fwd", fwd_valid, 1); chk("R12 replay no region", region_active, 0);
    rel(LA);    chk("R12 replay rel fwd", fwd_valid, 1);
  endtask

  task automatic t_reset();
    chk("R1 region", region_active, 0); chk("R1 commit", commit_req, 0);
    chk("R1 reexec", reexec_req, 0);    chk("R1 fwd", fwd_valid, 0);
    chk("R1 rd", rd_valid, 0);          chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_basic();
    acq(LA, 32'hA5);  chk("R2 absorbed", fwd_valid, 0); chk("R2 region", region_active, 1);
    ld(LA);           chk("R3 rd_valid", rd_valid, 1); chk("R3 rd_data", rd_data, 32'hA5);
                      chk("R3 no fwd", fwd_valid, 0);
    ld(LB);           chk("R4 load fwd", fwd_valid, 1); chk("R4 no rd", rd_valid, 0);
    st(LB);           chk("R4 store fwd", fwd_valid, 1); chk("R4 no abort", reexec_req, 0);
    rel(LA);          chk("R9 commit", commit_req, 1); chk("R9 closed", region_active, 0);
  endtask

  task automatic t_nested_full();
    acq(LA, 1); acq(LC, 2);
    acq(LD, 3);  chk("R6 third fwd", fwd_valid, 1); chk("R6 no abort", reexec_req, 0);
                 chk("R6 still open", region_active, 1);
    rel(LD);     chk("R10 unmatched rel fwd", fwd_valid, 1);
    rel(LC);     chk("R9 inner no commit", commit_req, 0); chk("R9 inner open", region_active, 1);
    ld(LC);      chk("R9 freed entry fwd", fwd_valid, 1);
    rel(LA);     chk("R9 outer commit", commit_req, 1);
  endtask

  task automatic t_cross();
    req(1, 2'd1, 32'h13E, 2'd2, 7, 0);
    chk("R5 cross fwd", fwd_valid, 1); chk("R5 cross no region", region_active, 0);
    req(1, 2'd1, 32'h13C, 2'd2, 7, 0);
    chk("R2 edge fits absorbed", region_active, 1); chk("R2 edge no fwd", fwd_valid, 0);
    req(1, 2'd1, 32'h17F, 2'd1, 7, 0);
    chk("R5 cross in region abort", reexec_req, 1); chk("R5 region dropped", region_active, 0);
    leave_replay();
  endtask

  task automatic t_store_lock();
    acq(LA, 1); st(LA);
    chk("R7 store abort", reexec_req, 1); chk("R7 region", region_active, 0);
    leave_replay();
  endtask

  task automatic t_recursive();
    acq(LA, 1); acq(LA, 2);
    chk("R8 recursive abort", reexec_req, 1);
    acq(LC, 1); chk("R12 nested replay acq fwd", fwd_valid, 1);
    acq(LA, 1); chk("R12 inner replay acq fwd", fwd_valid, 1);
    rel(LA);    chk("R12 inner replay rel fwd", fwd_valid, 1);
    rel(LC);    chk("R12 outer replay rel fwd", fwd_valid, 1);
    acq(LA, 9); chk("R12 elision resumes", region_active, 1); chk("R12 resumes no fwd", fwd_valid, 0);
    rel(LA);    chk("R12 resumed commit", commit_req, 1);
  endtask

  task automatic t_ext_abort();
    req(0, 2'd0, LB, 2'd2, 0, 1);
    chk("R11 idle abort ignored", reexec_req, 0); chk("R11 idle fwd", fwd_valid, 1);
    acq(LA, 4);
    @(negedge clk); abort_in = 1'b1; @(posedge clk); #1; abort_in = 1'b0;
    chk("R11 reexec", reexec_req, 1); chk("R11 not ready", req_ready, 0);
    ld(LA); chk("R11 dropped lock fwd", fwd_valid, 1);
    leave_replay();
  endtask

  task automatic t_collide();
    acq(LA, 1);
    req(1, 2'd2, LA, 2'd2, 0, 1);
    chk("R13 reexec", reexec_req, 1); chk("R13 no commit", commit_req, 0);
    ld(LA); chk("R13 lock discarded", fwd_valid, 1);
    leave_replay();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_nested_full();
    t_cross();
    t_store_lock();
    t_recursive();
    t_ext_abort();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule